// File: doc/BRIEF.md
# Drift-Corrected Nanosecond Time Counter

This block keeps a 64-bit time of day in nanoseconds for precision time stamping. While it runs, it advances by a fixed nominal step on every clock. A drift corrector trims the rate. It counts elapsed nanoseconds against a programmable interval, and each time the interval runs out it adds a small whole number of nanoseconds to that cycle's step or takes it away.

Software reaches the block through a simple word-wide register port. Through it software can:
- stop the counter, write a new start value into the two halves, and start it again;
- hold the drift logic in reset, write its configuration word while it is held, and release it to start correcting;
- read the current time as a low word followed by a high word.

Reading the low word saves the matching high word in a shadow register, so the two reads always describe the same instant.

Top module: `drift_tod_counter`

## Requirements
- R1: After reset the time is 0 and counting. The control register (address 0) reads 1. The drift reset bit (address 4, bit 0) reads 0. The drift configuration word (address 3) reads 0.
- R2: On every clock edge where the counter runs and no correction is due, the time grows by STEP_NS (default 16).
- R3: Writing 2 to address 0 stops the counter, and writing 4 resumes it. Any other value written there is ignored. Bit 0 of address 0 reads 1 while running and 0 while stopped. While stopped, the time does not change except through loads.
- R4: While stopped, a write to address 1 replaces time bits 31:0 and a write to address 2 replaces time bits 63:32. While running, both writes are ignored.
- R5: Address 3 takes a new configuration word only while the drift reset bit is 1. Otherwise a write there leaves the stored word unchanged. Both registers read back what they hold.
- R6: The configuration word holds the period P in bits 27:0. The correction interval is P×16+8 ns. A nanosecond timer advances by STEP_NS on each running cycle. A correction is applied on the cycle where the timer would reach the interval, and the timer then restarts from 0. The timer is held at 0 while the drift reset bit is 1, and it does not advance while the counter is stopped. With the default step, corrections fall on every (P+1)-th running cycle after the release.
- R7: Bits 30:28 of the configuration word give the correction size V (0 to 7 ns). Bit 31 gives the direction: 1 adds V to the step of the correcting cycle, and 0 subtracts it.
- R8: No correction changes the time while the drift reset bit is 1 or while the configuration word is all zeros. A word with V = 0 leaves the rate nominal.
- R9: A period field of 0 acts as a period of 1.
- R10: A read of address 5 returns time bits 31:0 and, at that edge, copies time bits 63:32 into a shadow register. Address 6 reads the shadow register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; marks a read that has side effects (address 5) |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
Two events can fall on the same edge: a read of the low word, and the carry out of the low half into the high half. The bench loads a low half just below wrap while the counter is stopped, resumes it, and reads the low word on the first running edge. The expected high word must be the value before the carry, and a second read must show the carried value with a low word of zero. The drift timer and the stop control can also meet. The bench opens measurement windows that end on cycle counts both on and off a correction boundary, and compares the time gained with nominal steps plus the corrections that the requirements predict.

// File: rtl/drift_tod_counter.sv
module drift_tod_counter #(
  parameter int STEP_NS = 16,
  parameter int PER_W   = 28,
  parameter int VAL_W   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata
);
  localparam int IVL_W  = PER_W + 5;
  localparam int DIR_B  = PER_W + VAL_W;
  localparam logic [2:0] A_CTRL = 3'd0, A_LDLO = 3'd1, A_LDHI = 3'd2,
                         A_DCFG = 3'd3, A_DRST = 3'd4, A_TLO  = 3'd5,
                         A_THI  = 3'd6;

  logic             running;
  logic [63:0]      tod;
  logic [31:0]      shadow;
  logic [31:0]      dcfg;
  logic             drst;
  logic [IVL_W-1:0] tmr;

  wire [PER_W-1:0] per_f  = dcfg[PER_W-1:0];
  wire [PER_W-1:0] per_e  = (per_f == '0) ? PER_W'(1) : per_f;
  wire [IVL_W-1:0] ivl    = (IVL_W'(per_e) << 4) | IVL_W'(8);
  wire [VAL_W-1:0] val    = dcfg[DIR_B-1:PER_W];
  wire             dir_up = dcfg[DIR_B];
  wire             d_on   = !drst && (dcfg != '0);
  wire [IVL_W-1:0] tmr_nx = tmr + IVL_W'(STEP_NS);
  wire             fire   = running && d_on && (tmr_nx >= ivl);

  wire [63:0] inc = !fire  ? 64'(STEP_NS) :
                    dir_up ? 64'(STEP_NS) + 64'(val) :
                             64'(STEP_NS) - 64'(val);

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_ldlo = reg_wr && reg_addr == A_LDLO;
  wire wr_ldhi = reg_wr && reg_addr == A_LDHI;

  always_ff @(posedge clk) begin
    if (!rst_n) running <= 1'b1;
    else if (wr_ctrl && reg_wdata == 32'd2) running <= 1'b0;
    else if (wr_ctrl && reg_wdata == 32'd4) running <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tod <= '0;
    else if (running) tod <= tod + inc;
    else if (wr_ldlo) tod[31:0] <= reg_wdata;
    else if (wr_ldhi) tod[63:32] <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drst <= 1'b0;
      dcfg <= '0;
    end else begin
      if (reg_wr && reg_addr == A_DRST) drst <= reg_wdata[0];
      if (reg_wr && reg_addr == A_DCFG && drst) dcfg <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !d_on) tmr <= '0;
    else if (fire) tmr <= '0;
    else if (running) tmr <= tmr_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shadow <= '0;
    else if (reg_rd && reg_addr == A_TLO) shadow <= tod[63:32];
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {31'd0, running};
      A_DCFG:  reg_rdata = dcfg;
      A_DRST:  reg_rdata = {31'd0, drst};
      A_TLO:   reg_rdata = tod[31:0];
      A_THI:   reg_rdata = shadow;
      default: reg_rdata = '0;
    endcase
  end

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_ldlo && !wr_ldhi) |=> $stable(tod)); // R3
  AST_HELD_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (running && drst) |=> (tod == $past(tod) + 64'(STEP_NS))); // R8
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !drst |=> $stable(dcfg)); // R5
  AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    drst |=> (tmr == '0)); // R6
  AST_TMR_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    d_on |-> (tmr < ivl)); // R6
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ((tod - $past(tod)) <= 64'(STEP_NS + 7) &&
                 (tod - $past(tod)) >= 64'(STEP_NS - 7))); // R7
  AST_SHADOW_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_TLO) |=> (shadow == $past(tod[63:32]))); // R10
endmodule

// File: tb/sim_drift_tod_counter.sv
`timescale 1ns/1ps
module sim_drift_tod_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  drift_tod_counter u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd64(output logic [31:0] lo, output logic [31:0] hi);
    reg_rd = 1'b1; reg_addr = 3'd5;
    #1 lo = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 3'd6;
    #1 hi = reg_rdata;
  endtask

  task automatic drift_window(input logic [31:0] cfg, input bit release_rst,
                              input int m, output logic [31:0] delta);
    logic [31:0] l0, l1;
    wr(3'd0, 32'd2);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd4, 32'd1);
    wr(3'd3, cfg);
    if (release_rst) wr(3'd4, 32'd0);
    rd(3'd5, l0);
    wr(3'd0, 32'd4);
    repeat (m) @(posedge clk);
    @(negedge clk);
    rd(3'd5, l1);
    delta = l1 - l0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd5, d); chk("R1 time low", d, 0);
    rd(3'd0, d); chk("R1 running", d, 1);
    rd(3'd4, d); chk("R1 drift reset", d, 0);
    rd(3'd3, d); chk("R1 drift cfg", d, 0);
  endtask

  task automatic t_nominal;
    logic [31:0] a, b;
    @(negedge clk);
    rd(3'd5, a);
    repeat (20) @(posedge clk);
    @(negedge clk);
    rd(3'd5, b);
    chk("R2 nominal step", b - a, 320);
  endtask

  task automatic t_pause;
    logic [31:0] a, b, c;
    wr(3'd0, 32'd2);
    rd(3'd0, c); chk("R3 stopped flag", c, 0);
    rd(3'd5, a);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(3'd5, b); chk("R3 hold while stopped", b, a);
    wr(3'd0, 32'd7);
    rd(3'd0, c); chk("R3 other command ignored", c, 0);
  endtask

  task automatic t_load_and_carry;
    logic [31:0] lo, hi, a, b;
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd2, 32'd7);
    rd64(lo, hi);
    chk("R4 load low", lo, 32'hFFFF_FFF0);
    chk("R4 load high", hi, 7);
    wr(3'd0, 32'd4);
    rd64(lo, hi);
    chk("R10 snapshot low at carry", lo, 32'hFFFF_FFF0);
    chk("R10 snapshot high before carry", hi, 7);
    rd64(lo, hi);
    chk("R10 low after carry", lo, 0);
    chk("R10 high after carry", hi, 8);
    rd(3'd5, a);
    wr(3'd1, 32'h55);
    rd(3'd5, b);
    chk("R4 load ignored while running", b, a + 32'd16);
    rd64(lo, hi);
    chk("R4 high unchanged while running", hi, 8);
  endtask

  task automatic t_cfg_lock;
    logic [31:0] d;
    wr(3'd4, 32'd0);
    wr(3'd3, 32'h1234_5678);
    rd(3'd3, d); chk("R5 cfg write ignored when not held", d, 0);
    wr(3'd4, 32'd1);
    rd(3'd4, d); chk("R5 drift reset readback", d, 1);
    wr(3'd3, 32'h1234_5678);
    rd(3'd3, d); chk("R5 cfg accepted while held", d, 32'h1234_5678);
  endtask

  task automatic t_drift;
    logic [31:0] dl;
    drift_window({1'b1, 3'd3, 28'd4}, 1'b1, 100, dl);
    chk("R6 R7 add 3ns every 5 cycles", dl, 1600 + 60);
    drift_window({1'b1, 3'd3, 28'd4}, 1'b1, 103, dl);
    chk("R6 off-boundary window", dl, 1648 + 60);
    drift_window({1'b0, 3'd5, 28'd9}, 1'b1, 100, dl);
    chk("R7 subtract 5ns every 10 cycles", dl, 1600 - 50);
    drift_window({1'b1, 3'd2, 28'd0}, 1'b1, 100, dl);
    chk("R9 period 0 acts as 1", dl, 1600 + 100);
    drift_window(32'h0FFF_FFFF, 1'b1, 100, dl);
    chk("R8 no-drift word", dl, 1600);
    drift_window({1'b1, 3'd0, 28'd1}, 1'b1, 100, dl);
    chk("R8 zero correction value", dl, 1600);
    drift_window({1'b1, 3'd7, 28'd1}, 1'b0, 100, dl);
    chk("R8 held in reset", dl, 1600);
    drift_window(32'd0, 1'b1, 100, dl);
    chk("R8 all-zero word disabled", dl, 1600);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_nominal;
    t_pause;
    t_load_and_carry;
    t_cfg_lock;
    t_drift;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule